// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block drives the processor reset line of a supervisor chip. Three conditions hold reset. After power-up it stays asserted until the supply-good flag from an external comparator has been true without a break for a programmed delay. During operation a drop of that flag asserts reset again. Reset then stays asserted until the flag has been true for the full delay once more.

The third condition is a watchdog on the chip-select pin. The host must drive a high-to-low transition on that pin inside a selected window. If the pin rests at either level for longer than the window, the block issues a reset pulse of fixed length. A two-bit select code from the status register picks one of three windows or turns the watchdog off. Off is also the factory value.

All delays count pulses of a slow timebase enable input, and parameters set the length of each delay in pulses. A parameter also picks the output polarity. The supply-good flag is expected to be synchronous to `clk`. The chip-select pin is treated as asynchronous.

Top module: `supv_reset_gen`

## Requirements
- R1: After `rst_n` is released, reset stays asserted until `supply_ok` has been high for PWR_TICKS timebase pulses without a break. Reset releases on the clock edge that takes the PWR_TICKS-th pulse.
- R2: A low `supply_ok` asserts reset on the next clock edge and restarts the delay count. Reset releases only after PWR_TICKS further pulses with `supply_ok` high throughout.
- R3: The watchdog window is set by `wd_sel`. Code 00 gives WD_LONG pulses, 01 gives WD_MID pulses and 10 gives WD_SHORT pulses. If that many pulses pass without a restart, reset asserts on the edge that takes the last pulse.
- R4: Only a falling edge of `cs_wdi` restarts the watchdog count. The edge is seen after a two-flop synchronizer. A rising edge does not restart the count, and a pin held low times out just as a pin held high does.
- R5: A watchdog timeout holds reset for RST_TICKS timebase pulses. Reset then releases.
- R6: With `wd_sel` = 11 the watchdog never asserts reset, whatever `cs_wdi` does.
- R7: While reset is asserted for any cause, the watchdog count is held at zero. After release, a full window must pass before a timeout.
- R8: A change of `wd_sel` restarts the watchdog count, so the new window runs from the change.
- R9: With ACTIVE_HIGH = 0, `sys_reset` is low while reset is asserted. With ACTIVE_HIGH = 1, it is high while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset of the logic |
| tick | input | 1 | Timebase enable, one clock wide per pulse |
| supply_ok | input | 1 | Supply-good flag from the comparator |
| cs_wdi | input | 1 | Chip-select / watchdog input pin, asynchronous |
| wd_sel | input | 2 | Watchdog window select code |
| sys_reset | output | 1 | Processor reset, polarity set by ACTIVE_HIGH |

## Verification
The bench uses a power-up delay of 8 pulses and a watchdog reset of 5 pulses. The windows are 12, 7 and 4 pulses. With these values every timeout and release edge, including the edge just before it, is reached within a few hundred clocks. The bench builds two copies of the block, one for each ACTIVE_HIGH value, and compares their outputs at every check. The bench drives the timebase pulses itself, so it can check the release and timeout edges at the exact pulse on which they occur.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_code_e;

  // window length in timebase pulses for a select code; 0 means watchdog off
  function automatic int unsigned wd_window(input logic [1:0] code,
                                            input int unsigned t_long,
                                            input int unsigned t_mid,
                                            input int unsigned t_short);
    case (wd_code_e'(code))
      WD_LONG:  return t_long;
      WD_MID:   return t_mid;
      WD_SHORT: return t_short;
      default:  return 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a, b, c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/supv_edge_sync.sv
module supv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/supv_supply_hold.sv
module supv_supply_hold #(
  parameter int unsigned DLY_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  output logic hold_o
);
  localparam int CW = (DLY_TICKS > 1) ? $clog2(DLY_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_o <= 1'b1;
      cnt    <= '0;
    end else if (!supply_ok) begin
      hold_o <= 1'b1;
      cnt    <= '0;
    end else if (hold_o && tick) begin
      if (cnt == LAST) begin
        hold_o <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2
  supply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> hold_o);
  // R1
  release_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> $past(supply_ok) && $past(tick));
endmodule

// File: rtl/supv_wd_counter.sv
module supv_wd_counter
  import supv_pkg::*;
#(
  parameter int unsigned T_LONG  = 1400,
  parameter int unsigned T_MID   = 600,
  parameter int unsigned T_SHORT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick,
  input  logic       hold_clear,
  input  logic [1:0] wd_sel,
  output logic       expire_o
);
  localparam int unsigned TMAX = max3(T_LONG, T_MID, T_SHORT);
  localparam int CW = (TMAX > 1) ? $clog2(TMAX) : 1;

  logic [1:0]    sel_q;
  logic [CW-1:0] cnt;
  logic          enabled, sel_chg, restart, at_last;
  int unsigned   window;

  always_comb begin
    window  = wd_window(wd_sel, T_LONG, T_MID, T_SHORT);
    enabled = (wd_code_e'(wd_sel) != WD_OFF);
    sel_chg = (wd_sel != sel_q);
    restart = !enabled || hold_clear || kick || sel_chg;
    at_last = (window != 0) && (32'(cnt) == window - 1);
  end

  assign expire_o = !restart && tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= WD_OFF;
      cnt   <= '0;
    end else begin
      sel_q <= wd_sel;
      if (restart)             cnt <= '0;
      else if (tick && at_last) cnt <= '0;
      else if (tick)            cnt <= cnt + CW'(1);
    end
  end

  // R3
  cnt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && $stable(wd_sel)) |-> (32'(cnt) < window));
  // R7
  held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clear |=> (cnt == '0));
endmodule

// File: rtl/supv_pulse_stretch.sv
module supv_pulse_stretch #(
  parameter int unsigned LEN_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trigger,
  output logic active_o
);
  localparam int CW = (LEN_TICKS > 1) ? $clog2(LEN_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      cnt      <= '0;
    end else if (trigger && !active_o) begin
      active_o <= 1'b1;
      cnt      <= '0;
    end else if (active_o && tick) begin
      if (cnt == LAST) begin
        active_o <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(trigger));
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter bit          ACTIVE_HIGH = 1'b0,
  parameter int unsigned PWR_TICKS   = 200,
  parameter int unsigned RST_TICKS   = 200,
  parameter int unsigned WD_LONG     = 1400,
  parameter int unsigned WD_MID      = 600,
  parameter int unsigned WD_SHORT    = 200,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic       cs_wdi,
  input  logic [1:0] wd_sel,
  output logic       sys_reset
);
  logic cs_fall;
  logic sup_hold;
  logic wd_expire;
  logic wd_active;
  logic rst_any;

  supv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cs_wdi), .fall_o(cs_fall));

  supv_supply_hold #(.DLY_TICKS(PWR_TICKS)) u_supply (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .hold_o(sup_hold));

  supv_wd_counter #(.T_LONG(WD_LONG), .T_MID(WD_MID), .T_SHORT(WD_SHORT)) u_wd (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(cs_fall),
    .hold_clear(rst_any), .wd_sel(wd_sel), .expire_o(wd_expire));

  supv_pulse_stretch #(.LEN_TICKS(RST_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trigger(wd_expire),
    .active_o(wd_active));

  assign rst_any = sup_hold | wd_active;

  generate
    if (ACTIVE_HIGH) begin : g_pol_hi
      assign sys_reset = rst_any;
    end else begin : g_pol_lo
      assign sys_reset = ~rst_any;
    end
  endgenerate

  // R6
  wd_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_sel == 2'b11) |-> !wd_expire);
  // R7
  no_expire_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_any |-> !wd_expire);
endmodule

// File: tb/tb_supv_reset_gen.sv
`timescale 1ns/1ps
module tb_supv_reset_gen;
  localparam int PWR = 8, RST = 5, WL = 12, WM = 7, WS = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, supply_ok = 1'b0, cs_wdi = 1'b1;
  logic [1:0] wd_sel = 2'b11;
  logic rst_lo, rst_hi;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  supv_reset_gen #(.ACTIVE_HIGH(1'b0), .PWR_TICKS(PWR), .RST_TICKS(RST),
    .WD_LONG(WL), .WD_MID(WM), .WD_SHORT(WS)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .cs_wdi(cs_wdi), .wd_sel(wd_sel), .sys_reset(rst_lo));

  supv_reset_gen #(.ACTIVE_HIGH(1'b1), .PWR_TICKS(PWR), .RST_TICKS(RST),
    .WD_LONG(WL), .WD_MID(WM), .WD_SHORT(WS)) dut_hi (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .cs_wdi(cs_wdi), .wd_sel(wd_sel), .sys_reset(rst_hi));

  task automatic chk(input string req, input logic exp_asserted);
    n_chk++;
    if (rst_lo !== ~exp_asserted) begin
      n_bad++;
      $display("FAIL %s: active-low reset actual %b expected %b at %0t",
               req, rst_lo, ~exp_asserted, $time);
    end
    n_chk++;
    if (rst_hi !== exp_asserted) begin // R9 polarity of second copy
      n_bad++;
      $display("FAIL R9 (%s): active-high reset actual %b expected %b at %0t",
               req, rst_hi, exp_asserted, $time);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse_tick();
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    wd_sel = 2'b11;
    ticks(RST + 1);
    chk("R6 settle released", 1'b0);
  endtask

  task automatic t_powerup();
    wait_clk(3);
    chk("R1 reset state", 1'b1);
    rst_n = 1'b1;
    supply_ok = 1'b1;
    wait_clk(2);
    ticks(PWR - 1);
    chk("R1 held one pulse before delay", 1'b1);
    pulse_tick();
    chk("R1 released after delay", 1'b0);
  endtask

  task automatic t_supply_drop();
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk);
    chk("R2 assert on supply low", 1'b1);
    supply_ok = 1'b1;
    ticks(3);
    supply_ok = 1'b0;
    @(negedge clk) supply_ok = 1'b1;
    ticks(PWR - 1);
    chk("R2 glitch restarted delay", 1'b1);
    pulse_tick();
    chk("R2 released after full delay", 1'b0);
  endtask

  task automatic t_window(input logic [1:0] code, input int w, input string tag);
    settle();
    wd_sel = code;
    wait_clk(2);
    ticks(w - 1);
    chk({"R3 no timeout before window ", tag}, 1'b0);
    pulse_tick();
    chk({"R3 timeout at window ", tag}, 1'b1);
    ticks(RST - 1);
    chk("R5 watchdog reset still held", 1'b1);
    pulse_tick();
    chk("R5 watchdog reset released", 1'b0);
  endtask

  task automatic t_disabled();
    settle();
    ticks(WL + 3);
    cs_wdi = 1'b0;
    ticks(WL + 3);
    chk("R6 disabled never times out", 1'b0);
    cs_wdi = 1'b1;
    wait_clk(4);
  endtask

  task automatic t_kick();
    settle();
    wd_sel = 2'b10;
    wait_clk(2);
    ticks(WS - 1);
    cs_wdi = 1'b0;
    wait_clk(4);
    ticks(WS - 1);
    chk("R4 falling edge restarted count", 1'b0);
    cs_wdi = 1'b1;
    wait_clk(4);
    pulse_tick();
    chk("R4 rising edge did not restart", 1'b1);
    settle();
    cs_wdi = 1'b0;
    wait_clk(4);
    wd_sel = 2'b10;
    wait_clk(2);
    ticks(WS - 1);
    chk("R4 stuck low before window", 1'b0);
    pulse_tick();
    chk("R4 stuck low times out", 1'b1);
    cs_wdi = 1'b1;
    settle();
  endtask

  task automatic t_held_clear();
    settle();
    wd_sel = 2'b10;
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk) supply_ok = 1'b1;
    ticks(PWR);
    chk("R7 supply hold released", 1'b0);
    ticks(WS - 1);
    chk("R7 full window after release", 1'b0);
    pulse_tick();
    chk("R7 timeout after full window", 1'b1);
    settle();
  endtask

  task automatic t_sel_change();
    settle();
    wd_sel = 2'b01;
    wait_clk(2);
    ticks(5);
    wd_sel = 2'b10;
    wait_clk(2);
    ticks(WS - 1);
    chk("R8 count restarted on select change", 1'b0);
    pulse_tick();
    chk("R8 new window applied", 1'b1);
    settle();
  endtask

  initial begin
    t_powerup();
    t_supply_drop();
    t_window(2'b00, WL, "00");
    t_window(2'b01, WM, "01");
    t_window(2'b10, WS, "10");
    t_disabled();
    t_kick();
    t_held_clear();
    t_sel_change();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule